// File: doc/BRIEF.md
# DDS Serial Command Register File

This block is the control-register side of a direct digital synthesizer that has two frequency tuning registers and four phase offset registers. A serial front end, which is outside this block, delivers complete 16-bit control words with a one-cycle valid strobe. The block decodes each word and keeps the tuning, phase and control state that a synthesis core reads.

A tuning or phase value is wider than the byte a single word carries, so it is written in byte pairs. A staging word parks a byte in a hidden holding register. The matching commit word then writes that held byte and its own byte into a 16-bit half of the target register in the same clock edge. The remaining command groups set the active-register selection, the sync and selection-source flags, and the sleep, reset and clear flags. The effective selection comes either from the control fields or from two external pins. The outputs also carry the currently selected frequency and phase values.

Top module: `dds_cmd_regfile`

## Requirements
- R1: A word is taken only on a clock edge where `wordValid` is 1. Its fields are command = `wordData[15:12]`, address = `wordData[11:8]` and data byte = `wordData[7:0]`. Its effect is visible on the outputs after that edge. While `wordValid` is 0, no state changes.
- R2: After reset, all frequency and phase registers are 0, both select fields are 0, `syncEn` and `srcSelect` are 0, and `sleepEn`, `resetEn` and `clrEn` are all 1.
- R3: A staging word writes only a hidden byte. Command 0x3 is frequency staging and must use an address in 0x0-0x7. Command 0x1 is phase staging and must use an address in 0x8-0xF. A staging word leaves `freqRegs` and `phaseRegs` unchanged.
- R4: Command 0x2 with address a in 0x0-0x7 is a frequency commit. It writes {staged frequency byte, data byte} into 16-bit half a[2:1] of `freqRegs`, at bits 16*a[2:1]+15 down to 16*a[2:1]. Frequency register n occupies bits 32n+31 down to 32n. Address bit 0 is ignored.
- R5: Command 0x0 with address a in 0x8-0xF is a phase commit. It writes {staged phase byte bits 3:0, data byte} into phase register a[2:1], at bits 12k+11 down to 12k of `phaseRegs`. Staged bits 7:4 are discarded.
- R6: A staging or commit word whose address lies in the other kind's range is ignored. It does not change the visible registers or the held byte.
- R7: Command 0x6 loads the frequency select from `wordData[11]` and the phase select from `wordData[10:9]`.
- R8: Commands 0x8-0xB load `syncEn` from `wordData[13]` and `srcSelect` from `wordData[12]`.
- R9: Commands 0xC-0xF load `sleepEn` from `wordData[13]`, `resetEn` from `wordData[12]` and `clrEn` from `wordData[11]`.
- R10: When `srcSelect` is 1, `activeFreqSel` and `activePhaseSel` follow the control fields. When it is 0, they follow `pinFreqSel` and `pinPhaseSel`. `activeFreq` and `activePhase` show the registers those selects point at.
- R11: Commands 0x4, 0x5 and 0x7 change nothing.
- R12: The held byte persists after a commit. A second commit with no new staging word reuses the last staged byte of its kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wordValid | input | 1 | Control word strobe |
| wordData | input | 16 | Control word |
| pinFreqSel | input | 1 | External frequency register select |
| pinPhaseSel | input | 2 | External phase register select |
| freqRegs | output | 64 | Both frequency registers, register 1 in the upper 32 bits |
| phaseRegs | output | 48 | Four phase registers, register k at bits 12k+11:12k |
| syncEn | output | 1 | Sync flag |
| srcSelect | output | 1 | 1: control fields select, 0: pins select |
| sleepEn | output | 1 | Sleep flag |
| resetEn | output | 1 | Reset flag |
| clrEn | output | 1 | Clear flag |
| activeFreqSel | output | 1 | Effective frequency select |
| activePhaseSel | output | 2 | Effective phase select |
| activeFreq | output | 32 | Selected frequency register |
| activePhase | output | 12 | Selected phase register |

## Verification
The bench writes a full frequency value as two staged pairs, then issues a commit that reuses a stale held byte. A design that cleared the held byte after a commit would write zero into the upper byte. Staging and commit words are sent with addresses in the wrong range. A decoder that ignored address bit 3 would corrupt the other bank or overwrite the held byte. A phase high byte with its upper nibble set must not leak past bit 11. The unassigned command codes are sent, and the sync and power groups are decoded from bits that overlap the command field. Finally, switching `srcSelect` must move the active outputs between the pins and the control fields.

// File: rtl/dds_cmd_pkg.sv
package dds_cmd_pkg;
  localparam int WORD_W = 16;
  localparam int CMD_W  = 4;
  localparam int ADDR_W = 4;
  localparam int BYTE_W = 8;

  localparam logic [CMD_W-1:0] CMD_PHASE_COMMIT = 4'h0;
  localparam logic [CMD_W-1:0] CMD_PHASE_STAGE  = 4'h1;
  localparam logic [CMD_W-1:0] CMD_FREQ_COMMIT  = 4'h2;
  localparam logic [CMD_W-1:0] CMD_FREQ_STAGE   = 4'h3;
  localparam logic [CMD_W-1:0] CMD_SELECT       = 4'h6;

  // Strobes from the decoder to the register store
  typedef struct packed {
    logic              stageFreq;
    logic              stagePhase;
    logic              commitFreq;
    logic              commitPhase;
    logic              loadSelect;
    logic              loadSync;
    logic              loadPower;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] dataByte;
    logic [2:0]        selBits;   // word bits 11:9
    logic [2:0]        ctlBits;   // word bits 13:11
  } dds_strobe_t;
endpackage

// File: rtl/dds_cmd_decode.sv
module dds_cmd_decode
  import dds_cmd_pkg::*;
(
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordData,
  output dds_strobe_t       strobe
);
  logic [CMD_W-1:0]  cmd;
  logic [ADDR_W-1:0] addr;
  logic              phaseBank;

  assign cmd       = wordData[WORD_W-1 -: CMD_W];
  assign addr      = wordData[BYTE_W +: ADDR_W];
  assign phaseBank = addr[ADDR_W-1];

  always_comb begin
    strobe          = '0;
    strobe.addr     = addr;
    strobe.dataByte = wordData[BYTE_W-1:0];
    strobe.selBits  = wordData[11:9];
    strobe.ctlBits  = wordData[13:11];
    if (wordValid) begin
      case (cmd)
        CMD_PHASE_COMMIT: strobe.commitPhase = phaseBank;
        CMD_PHASE_STAGE:  strobe.stagePhase  = phaseBank;
        CMD_FREQ_COMMIT:  strobe.commitFreq  = !phaseBank;
        CMD_FREQ_STAGE:   strobe.stageFreq   = !phaseBank;
        CMD_SELECT:       strobe.loadSelect  = 1'b1;
        default: begin
          strobe.loadSync  = (cmd[3:2] == 2'b10);
          strobe.loadPower = (cmd[3:2] == 2'b11);
        end
      endcase
    end
  end
endmodule

// File: rtl/dds_reg_store.sv
module dds_reg_store
  import dds_cmd_pkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 12,
  parameter int N_FREQ  = 2,
  parameter int N_PHASE = 4,
  localparam int FSEL_W = $clog2(N_FREQ),
  localparam int PSEL_W = $clog2(N_PHASE)
)(
  input  logic                      clk,
  input  logic                      rstN,
  input  dds_strobe_t               strobe,
  input  logic [FSEL_W-1:0]         pinFreqSel,
  input  logic [PSEL_W-1:0]         pinPhaseSel,
  output logic [N_FREQ*FREQ_W-1:0]  freqRegs,
  output logic [N_PHASE*PHASE_W-1:0] phaseRegs,
  output logic                      syncEn,
  output logic                      srcSelect,
  output logic                      sleepEn,
  output logic                      resetEn,
  output logic                      clrEn,
  output logic [FSEL_W-1:0]         activeFreqSel,
  output logic [PSEL_W-1:0]         activePhaseSel,
  output logic [FREQ_W-1:0]         activeFreq,
  output logic [PHASE_W-1:0]        activePhase
);
  localparam int HALF_W     = 2 * BYTE_W;
  localparam int N_HALF     = N_FREQ * FREQ_W / HALF_W;
  localparam int HIDX_W     = $clog2(N_HALF);
  localparam int PHASE_HI_W = PHASE_W - BYTE_W;

  logic [HALF_W-1:0]     halfReg  [N_HALF];
  logic [PHASE_W-1:0]    phaseReg [N_PHASE];
  logic [BYTE_W-1:0]     freqStage;
  logic [PHASE_HI_W-1:0] phaseStage;
  logic [FSEL_W-1:0]     freqSelCtl;
  logic [PSEL_W-1:0]     phaseSelCtl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int h = 0; h < N_HALF; h++) halfReg[h] <= '0;
      for (int k = 0; k < N_PHASE; k++) phaseReg[k] <= '0;
      freqStage   <= '0;
      phaseStage  <= '0;
      freqSelCtl  <= '0;
      phaseSelCtl <= '0;
      syncEn      <= 1'b0;
      srcSelect   <= 1'b0;
      sleepEn     <= 1'b1;
      resetEn     <= 1'b1;
      clrEn       <= 1'b1;
    end else begin
      if (strobe.stageFreq)  freqStage  <= strobe.dataByte;
      if (strobe.stagePhase) phaseStage <= strobe.dataByte[PHASE_HI_W-1:0];
      for (int h = 0; h < N_HALF; h++)
        if (strobe.commitFreq && strobe.addr[1 +: HIDX_W] == HIDX_W'(h))
          halfReg[h] <= {freqStage, strobe.dataByte};
      for (int k = 0; k < N_PHASE; k++)
        if (strobe.commitPhase && strobe.addr[1 +: PSEL_W] == PSEL_W'(k))
          phaseReg[k] <= {phaseStage, strobe.dataByte};
      if (strobe.loadSelect) begin
        freqSelCtl  <= FSEL_W'(strobe.selBits[2]);
        phaseSelCtl <= PSEL_W'(strobe.selBits[1:0]);
      end
      if (strobe.loadSync) begin
        syncEn    <= strobe.ctlBits[2];
        srcSelect <= strobe.ctlBits[1];
      end
      if (strobe.loadPower) begin
        sleepEn <= strobe.ctlBits[2];
        resetEn <= strobe.ctlBits[1];
        clrEn   <= strobe.ctlBits[0];
      end
    end
  end

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    assign freqRegs[h*HALF_W +: HALF_W] = halfReg[h];
  end
  for (genvar k = 0; k < N_PHASE; k++) begin : g_phase
    assign phaseRegs[k*PHASE_W +: PHASE_W] = phaseReg[k];
  end

  assign activeFreqSel  = srcSelect ? freqSelCtl  : pinFreqSel;
  assign activePhaseSel = srcSelect ? phaseSelCtl : pinPhaseSel;
  assign activeFreq     = freqRegs[activeFreqSel*FREQ_W +: FREQ_W];
  assign activePhase    = phaseRegs[activePhaseSel*PHASE_W +: PHASE_W];
endmodule

// File: rtl/dds_cmd_regfile.sv
module dds_cmd_regfile
  import dds_cmd_pkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 12,
  parameter int N_FREQ  = 2,
  parameter int N_PHASE = 4,
  localparam int FSEL_W = $clog2(N_FREQ),
  localparam int PSEL_W = $clog2(N_PHASE)
)(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wordValid,
  input  logic [WORD_W-1:0]          wordData,
  input  logic [FSEL_W-1:0]          pinFreqSel,
  input  logic [PSEL_W-1:0]          pinPhaseSel,
  output logic [N_FREQ*FREQ_W-1:0]   freqRegs,
  output logic [N_PHASE*PHASE_W-1:0] phaseRegs,
  output logic                       syncEn,
  output logic                       srcSelect,
  output logic                       sleepEn,
  output logic                       resetEn,
  output logic                       clrEn,
  output logic [FSEL_W-1:0]          activeFreqSel,
  output logic [PSEL_W-1:0]          activePhaseSel,
  output logic [FREQ_W-1:0]          activeFreq,
  output logic [PHASE_W-1:0]         activePhase
);
  dds_strobe_t strobe;

  dds_cmd_decode i_decode (
    .wordValid (wordValid),
    .wordData  (wordData),
    .strobe    (strobe)
  );

  dds_reg_store #(
    .FREQ_W  (FREQ_W),
    .PHASE_W (PHASE_W),
    .N_FREQ  (N_FREQ),
    .N_PHASE (N_PHASE)
  ) i_store (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .pinFreqSel     (pinFreqSel),
    .pinPhaseSel    (pinPhaseSel),
    .freqRegs       (freqRegs),
    .phaseRegs      (phaseRegs),
    .syncEn         (syncEn),
    .srcSelect      (srcSelect),
    .sleepEn        (sleepEn),
    .resetEn        (resetEn),
    .clrEn          (clrEn),
    .activeFreqSel  (activeFreqSel),
    .activePhaseSel (activePhaseSel),
    .activeFreq     (activeFreq),
    .activePhase    (activePhase)
  );
endmodule

// File: rtl/dds_cmd_regfile_chk.sv
module dds_cmd_regfile_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wordValid,
  input logic [15:0] wordData,
  input logic [63:0] freqRegs,
  input logic [47:0] phaseRegs,
  input logic        syncEn,
  input logic        srcSelect,
  input logic        sleepEn,
  input logic        resetEn,
  input logic        clrEn
);
  logic [3:0] cmd;
  assign cmd = wordData[15:12];

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |=> ($stable(freqRegs) && $stable(phaseRegs)));

  p_stage_hidden_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && (cmd == 4'h1 || cmd == 4'h3)) |=> ($stable(freqRegs) && $stable(phaseRegs)));

  p_freq_commit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && cmd == 4'h2 && !wordData[11])
      |=> (freqRegs[int'($past(wordData[10:9]))*16 +: 8] == $past(wordData[7:0])));

  p_phase_commit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && cmd == 4'h0 && wordData[11])
      |=> (phaseRegs[int'($past(wordData[10:9]))*12 +: 8] == $past(wordData[7:0])));

  p_sync_group_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && cmd[3:2] == 2'b10) |=> ({syncEn, srcSelect} == $past(wordData[13:12])));

  p_power_group_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && cmd[3:2] == 2'b11) |=> ({sleepEn, resetEn, clrEn} == $past(wordData[13:11])));

  p_unassigned_r11: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && (cmd == 4'h4 || cmd == 4'h5 || cmd == 4'h7))
      |=> ($stable(freqRegs) && $stable(phaseRegs)
           && $stable({syncEn, srcSelect, sleepEn, resetEn, clrEn})));
endmodule

bind dds_cmd_regfile dds_cmd_regfile_chk i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wordValid (wordValid),
  .wordData  (wordData),
  .freqRegs  (freqRegs),
  .phaseRegs (phaseRegs),
  .syncEn    (syncEn),
  .srcSelect (srcSelect),
  .sleepEn   (sleepEn),
  .resetEn   (resetEn),
  .clrEn     (clrEn)
);

// File: tb/test_dds_cmd_regfile.sv
`timescale 1ns/1ps
module test_dds_cmd_regfile;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wordValid = 1'b0;
  logic [15:0] wordData = '0;
  logic        pinFreqSel = 1'b0;
  logic [1:0]  pinPhaseSel = '0;
  logic [63:0] freqRegs;
  logic [47:0] phaseRegs;
  logic        syncEn, srcSelect, sleepEn, resetEn, clrEn;
  logic        activeFreqSel;
  logic [1:0]  activePhaseSel;
  logic [31:0] activeFreq;
  logic [11:0] activePhase;

  int applied = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  dds_cmd_regfile i_dds_cmd_regfile (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordData(wordData),
    .pinFreqSel(pinFreqSel), .pinPhaseSel(pinPhaseSel),
    .freqRegs(freqRegs), .phaseRegs(phaseRegs),
    .syncEn(syncEn), .srcSelect(srcSelect), .sleepEn(sleepEn),
    .resetEn(resetEn), .clrEn(clrEn),
    .activeFreqSel(activeFreqSel), .activePhaseSel(activePhaseSel),
    .activeFreq(activeFreq), .activePhase(activePhase)
  );

  // {word, expected freqRegs, expected phaseRegs}
  localparam logic [127:0] VEC [21] = '{
    {16'h33AB, 64'h00000000_00000000, 48'h000_000_000_000}, // R3 freq stage
    {16'h22CD, 64'h00000000_ABCD0000, 48'h000_000_000_000}, // R4 upper half
    {16'h3112, 64'h00000000_ABCD0000, 48'h000_000_000_000}, // R3
    {16'h2034, 64'h00000000_ABCD1234, 48'h000_000_000_000}, // R4 lower half
    {16'h3755, 64'h00000000_ABCD1234, 48'h000_000_000_000}, // R3
    {16'h2666, 64'h55660000_ABCD1234, 48'h000_000_000_000}, // R4 reg 1
    {16'h2477, 64'h55665577_ABCD1234, 48'h000_000_000_000}, // R12 reuse 0x55
    {16'h19F5, 64'h55665577_ABCD1234, 48'h000_000_000_000}, // R3 phase stage
    {16'h0867, 64'h55665577_ABCD1234, 48'h000_000_000_567}, // R5 nibble F dropped
    {16'h1F0A, 64'h55665577_ABCD1234, 48'h000_000_000_567}, // R3
    {16'h0EBC, 64'h55665577_ABCD1234, 48'hABC_000_000_567}, // R5 reg 3
    {16'h0C11, 64'h55665577_ABCD1234, 48'hABC_A11_000_567}, // R12 phase reuse
    {16'h4FFF, 64'h55665577_ABCD1234, 48'hABC_A11_000_567}, // R11
    {16'h5123, 64'h55665577_ABCD1234, 48'hABC_A11_000_567}, // R11
    {16'h7FFF, 64'h55665577_ABCD1234, 48'hABC_A11_000_567}, // R11
    {16'h2A99, 64'h55665577_ABCD1234, 48'hABC_A11_000_567}, // R6 freq commit in phase range
    {16'h0399, 64'h55665577_ABCD1234, 48'hABC_A11_000_567}, // R6 phase commit in freq range
    {16'h1322, 64'h55665577_ABCD1234, 48'hABC_A11_000_567}, // R6 phase stage in freq range
    {16'h0A44, 64'h55665577_ABCD1234, 48'hABC_A11_A44_567}, // R6 held 0xA kept
    {16'h3B33, 64'h55665577_ABCD1234, 48'hABC_A11_A44_567}, // R6 freq stage in phase range
    {16'h2600, 64'h55005577_ABCD1234, 48'hABC_A11_A44_567}  // R6 held 0x55 kept
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendWord(input logic [15:0] w);
    @(negedge clk);
    wordData  = w;
    wordValid = 1'b1;
    @(negedge clk);
    wordValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2 reset state
    check("R2 freqRegs", freqRegs, 64'h0);
    check("R2 phaseRegs", {16'h0, phaseRegs}, 64'h0);
    check("R2 control flags", {59'h0, syncEn, srcSelect, sleepEn, resetEn, clrEn}, 64'h7);

    for (int i = 0; i < 21; i++) begin
      sendWord(VEC[i][127:112]);
      check($sformatf("R1/R3-R6/R11/R12 vec%0d freq", i), freqRegs, VEC[i][111:48]);
      check($sformatf("R1/R3-R6/R11/R12 vec%0d phase", i), {16'h0, phaseRegs}, {16'h0, VEC[i][47:0]});
    end

    // R1: word without the valid strobe does nothing
    @(negedge clk);
    wordData = 16'h2000;
    @(negedge clk);
    @(negedge clk);
    check("R1 no strobe", freqRegs, 64'h55005577_ABCD1234);

    // R10: pins select while srcSelect is 0
    pinFreqSel  = 1'b1;
    pinPhaseSel = 2'd3;
    #1;
    check("R10 pin freq", {32'h0, activeFreq}, 64'h55005577);
    check("R10 pin phase", {52'h0, activePhase}, 64'hABC);

    // R7 + R8 + R10: control fields take over
    sendWord(16'h6A00);
    sendWord(16'h9000);
    pinFreqSel  = 1'b0;
    pinPhaseSel = 2'd0;
    #1;
    check("R8 sync/src", {62'h0, syncEn, srcSelect}, 64'h1);
    check("R7 selects", {61'h0, activeFreqSel, activePhaseSel}, 64'h5);
    check("R10 ctl freq", {32'h0, activeFreq}, 64'h55005577);
    check("R10 ctl phase", {52'h0, activePhase}, 64'hA44);

    // R8: sync on, source back to pins
    sendWord(16'hA000);
    check("R8 sync on", {62'h0, syncEn, srcSelect}, 64'h2);
    check("R10 back to pins", {32'h0, activeFreq}, 64'hABCD1234);

    // R9 power group
    sendWord(16'hC000);
    check("R9 all clear", {61'h0, sleepEn, resetEn, clrEn}, 64'h0);
    sendWord(16'hE800);
    check("R9 sleep+clr", {61'h0, sleepEn, resetEn, clrEn}, 64'h5);

    // R11: unassigned code leaves control flags alone
    sendWord(16'h7FFF);
    check("R11 flags held", {59'h0, syncEn, srcSelect, sleepEn, resetEn, clrEn}, 64'h15);

    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule